// File: doc/BRIEF.md
# Swap-Capable Bus Arbiter

This block lets several masters share a single synchronous memory port. Each master can issue a plain read, a plain write, or an atomic swap. A swap reads a location, then writes the value that came with the request back to the same location, and returns the old value to the requester. Masters typically build spin locks from it: a master swaps a "taken" value into a lock word and owns the lock when the old value shows it was free.

Ordinary arbitration is round-robin. Once a master wins, its request fields are latched and the grant stays with it until the transaction is finished. For a swap, that means both memory phases. Every other master waits for the whole pair, even if its access targets an unrelated address. Memory latency may stretch either phase: a phase finishes only in a cycle where the memory signals ready.

Top module: `swap_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no master is granted, `mem_req` is low and no done pulse is issued.
- R2: A read (op code 2'b00; code 2'b11 also behaves as a read) drives the owner's address with `mem_we` low. It returns to the requester the memory data present in the cycle the read is accepted.
- R3: A write (op code 2'b01) drives the owner's address and write data with `mem_we` high. The memory is updated once, when the write is accepted.
- R4: A swap (op code 2'b10) returns the value held at its address before the swap, and leaves the supplied write value stored there.
- R5: The cycle right after a swap's read phase is accepted, the arbiter presents the write phase to the same address. The grant is unchanged, and no other master is granted until the write is accepted.
- R6: While a swap is in progress, other requesting masters stay ungranted, whatever addresses they target.
- R7: Grants rotate round-robin. After master k finishes, the next grant goes to the first requesting master found searching upward from k+1, wrapping past the last master.
- R8: While `mem_req` is high and `mem_ready` is low, the request, address, write flag, write data and grant are all held stable into the next cycle.
- R9: Each transaction produces exactly one single-cycle done pulse to its requester, in the cycle after its final phase is accepted. `m_rdata` is valid in that cycle. A request still raised during that done cycle is not granted again.
- R10: Masters running swap-based spin locks on one lock word never hold the lock simultaneously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | NM | Per-master request, held until done |
| m_op | input | 2*NM | Per-master op code: 00 read, 01 write, 10 swap |
| m_addr | input | NM*AW | Per-master address |
| m_wdata | input | NM*DW | Per-master write or swap value |
| m_gnt | output | NM | One-hot owner of the memory port |
| m_done | output | NM | One-cycle completion pulse per master |
| m_rdata | output | DW | Read or swap old value, valid with done |
| mem_req | output | 1 | Memory phase request |
| mem_we | output | 1 | Memory phase is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory accepts the current phase |

## Verification
The embedded properties watch these rules on every cycle:
- the one-hot grant;
- the held handshake under a stalled memory;
- the write phase of a swap following its read immediately, at the same address and with the same owner;
- the shape and target of the done pulse.

Returned data values, the round-robin order, other masters stalling during a swap and lock exclusion depend on what masters ask for over many transactions. Only the bench's scenarios, with concurrent spin-lock masters and a shadow memory, show those.

// File: rtl/swap_arbiter.sv
module swap_arbiter #(
  parameter int NM = 4,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    m_req,
  input  logic [2*NM-1:0]  m_op,
  input  logic [NM*AW-1:0] m_addr,
  input  logic [NM*DW-1:0] m_wdata,
  output logic [NM-1:0]    m_gnt,
  output logic [NM-1:0]    m_done,
  output logic [DW-1:0]    m_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ready
);

  localparam int IW = (NM > 1) ? $clog2(NM) : 1;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_SW = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_PH1, S_PH2} state_t;

  state_t        state;
  logic [IW-1:0] owner, ptr, pick, owner_nxt;
  logic          pick_ok;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rbuf, rdata_q;
  logic [NM-1:0] done_q, eligible;

  assign eligible  = m_req & ~done_q;
  assign owner_nxt = (int'(owner) == NM-1) ? '0 : owner + 1'b1;

  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    for (int i = NM-1; i >= 0; i--) begin
      int j;
      j = int'(ptr) + i;
      if (j >= NM) j = j - NM;
      if (eligible[j]) begin
        pick_ok = 1'b1;
        pick    = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      owner   <= '0;
      ptr     <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rbuf    <= '0;
      rdata_q <= '0;
      done_q  <= '0;
    end else begin
      done_q <= '0;
      case (state)
        S_IDLE: if (pick_ok) begin
          owner   <= pick;
          op_q    <= m_op[2*pick +: 2];
          addr_q  <= m_addr[AW*pick +: AW];
          wdata_q <= m_wdata[DW*pick +: DW];
          state   <= S_PH1;
        end
        S_PH1: if (mem_ready) begin
          if (op_q == OP_SW) begin
            rbuf  <= mem_rdata;
            state <= S_PH2;
          end else begin
            rdata_q <= mem_rdata;
            done_q  <= NM'(1) << owner;
            ptr     <= owner_nxt;
            state   <= S_IDLE;
          end
        end
        S_PH2: if (mem_ready) begin
          rdata_q <= rbuf;
          done_q  <= NM'(1) << owner;
          ptr     <= owner_nxt;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (state != S_IDLE);
  assign mem_we    = (state == S_PH2) || (state == S_PH1 && op_q == OP_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign m_gnt     = mem_req ? (NM'(1) << owner) : '0;
  assign m_done    = done_q;
  assign m_rdata   = rdata_q;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (m_gnt == '0) |-> !mem_req);

  a_r5_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_gnt));

  a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !mem_we && op_q == OP_SW) |=>
      (mem_req && mem_we && mem_addr == $past(mem_addr) && m_gnt == $past(m_gnt)));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata) && $stable(m_gnt)));

  a_r9_done_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (m_done != '0) |-> ($onehot(m_done) && m_done == $past(m_gnt) && $past(mem_ready) && m_gnt == '0));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (m_done != '0) |=> (m_done == '0));

endmodule

// File: tb/sim_swap_arbiter.sv
module sim_swap_arbiter;
  localparam int CLK_NS = 10;
  localparam int NM = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [1:0] OP_RD = 2'b00, OP_WR = 2'b01, OP_SW = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic             b_req [NM];
  logic [1:0]       b_op  [NM];
  logic [AW-1:0]    b_addr[NM];
  logic [DW-1:0]    b_wd  [NM];
  logic [NM-1:0]    m_req;
  logic [2*NM-1:0]  m_op;
  logic [NM*AW-1:0] m_addr;
  logic [NM*DW-1:0] m_wdata;
  logic [NM-1:0]    m_gnt, m_done;
  logic [DW-1:0]    m_rdata, mem_wdata, mem_rdata;
  logic             mem_req, mem_we, mem_ready;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    model[2**AW];

  always_comb begin
    for (int i = 0; i < NM; i++) begin
      m_req[i]             = b_req[i];
      m_op[2*i +: 2]       = b_op[i];
      m_addr[AW*i +: AW]   = b_addr[i];
      m_wdata[DW*i +: DW]  = b_wd[i];
    end
  end
  assign mem_rdata = model[mem_addr];

  swap_arbiter #(.NM(NM), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_op(m_op), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_gnt(m_gnt), .m_done(m_done), .m_rdata(m_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready));

  int n_chk = 0, n_bad = 0;
  int ready_pct = 70;
  int holders = 0;
  int glog[$];
  int fin_cnt[NM];
  int txn_cnt[NM];
  logic [DW-1:0] exp_rd[NM];

  task automatic chk(input bit ok, input string r, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  function automatic int gidx(input logic [NM-1:0] g);
    int k = 0;
    for (int i = 0; i < NM; i++) if (g[i]) k = i;
    return k;
  endfunction

  logic          prev_wait = 1'b0, swap_pend = 1'b0;
  logic [AW-1:0] prev_addr = '0, swap_addr = '0;
  logic [NM-1:0] swap_gnt = '0, exp_done = '0, last_gnt = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      prev_wait = 1'b0;
      swap_pend = 1'b0;
      exp_done  = '0;
      last_gnt  = '0;
    end else begin
      int g;
      logic acc;
      if (exp_done != '0 || m_done != '0) chk(m_done == exp_done, "R9", "done pulse", m_done, exp_done);
      if (prev_wait) chk(mem_req && mem_addr == prev_addr, "R8", "held phase addr", mem_addr, prev_addr);
      if (m_gnt != '0 && last_gnt == '0) glog.push_back(gidx(m_gnt));
      if (swap_pend) begin
        chk(m_gnt == swap_gnt, "R5", "grant during swap", m_gnt, swap_gnt);
        for (int i = 0; i < NM; i++)
          if (b_req[i] && !swap_gnt[i]) chk(!m_gnt[i], "R6", "other master stalled", m_gnt, swap_gnt);
      end
      mem_ready = ($urandom_range(99) < ready_pct);
      acc = mem_req && mem_ready;
      g = gidx(m_gnt);
      exp_done = '0;
      prev_wait = mem_req && !mem_ready;
      prev_addr = mem_addr;
      if (acc) begin
        if (swap_pend) begin
          chk(mem_we && mem_addr == swap_addr, "R5", "swap write addr", mem_addr, swap_addr);
          chk(mem_wdata == b_wd[g], "R4", "swap write data", mem_wdata, b_wd[g]);
          model[mem_addr] = mem_wdata;
          swap_pend = 1'b0;
          exp_done = m_gnt;
        end else if (mem_we) begin
          chk(b_op[g] == OP_WR && mem_addr == b_addr[g] && mem_wdata == b_wd[g], "R3", "write phase",
              {mem_addr, mem_wdata}, {b_addr[g], b_wd[g]});
          model[mem_addr] = mem_wdata;
          exp_done = m_gnt;
        end else begin
          chk(mem_addr == b_addr[g], "R2", "read addr", mem_addr, b_addr[g]);
          exp_rd[g] = model[mem_addr];
          if (b_op[g] == OP_SW) begin
            swap_pend = 1'b1;
            swap_gnt  = m_gnt;
            swap_addr = mem_addr;
          end else exp_done = m_gnt;
        end
        if (exp_done != '0) fin_cnt[g]++;
      end
      last_gnt = m_gnt;
    end
  end

  task automatic txn(input int i, input logic [1:0] op, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, output logic [DW-1:0] rd);
    b_op[i] = op; b_addr[i] = a; b_wd[i] = d; b_req[i] = 1'b1;
    txn_cnt[i]++;
    do @(negedge clk); while (!m_done[i]);
    rd = m_rdata;
    if (op != OP_WR) chk(rd == exp_rd[i], op == OP_SW ? "R4" : "R2", "returned data", rd, exp_rd[i]);
    @(negedge clk);
    b_req[i] = 1'b0;
  endtask

  task automatic spinner(input int i, input int rounds);
    logic [DW-1:0] rd;
    for (int r = 0; r < rounds; r++) begin
      do txn(i, OP_SW, 8'h00, DW'(i + 1), rd); while (rd != '0);
      holders++;
      chk(holders == 1, "R10", "lock holders", holders, 1);
      for (int k = 0; k < 1 + int'($urandom_range(2)); k++)
        txn(i, ($urandom_range(1) != 0) ? OP_WR : OP_RD, AW'(16*(i+1) + int'($urandom_range(15))),
            DW'($urandom), rd);
      holders--;
      txn(i, OP_WR, 8'h00, '0, rd);
    end
  endtask

  task automatic mixer(input int i, input int n);
    logic [DW-1:0] rd;
    logic [1:0] op;
    for (int k = 0; k < n; k++) begin
      op = 2'($urandom_range(3));
      txn(i, op, AW'(64 + int'($urandom_range(191))), DW'($urandom), rd);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int last;
    void'($urandom(32'd2024));
    for (int i = 0; i < NM; i++) begin
      b_req[i] = 1'b0; b_op[i] = OP_RD; b_addr[i] = '0; b_wd[i] = '0;
      fin_cnt[i] = 0; txn_cnt[i] = 0; exp_rd[i] = '0;
    end
    for (int a = 0; a < 2**AW; a++) model[a] = '0;
    repeat (3) @(negedge clk);
    chk(m_gnt == '0 && !mem_req && m_done == '0, "R1", "reset outputs", {m_gnt, mem_req, m_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_gnt == '0 && !mem_req, "R1", "first cycle after reset", {m_gnt, mem_req}, 0);

    ready_pct = 100;
    txn(0, OP_WR, 8'd5, 16'hA55A, rd);
    txn(1, OP_RD, 8'd5, '0, rd);
    chk(rd == 16'hA55A, "R3", "write then read back", rd, 16'hA55A);
    txn(2, OP_WR, 8'd40, 16'h1234, rd);
    txn(3, OP_SW, 8'd40, 16'hBEEF, rd);
    chk(rd == 16'h1234, "R4", "swap old value", rd, 16'h1234);
    txn(0, OP_RD, 8'd40, '0, rd);
    chk(rd == 16'hBEEF, "R4", "swap new value stored", rd, 16'hBEEF);

    repeat (3) @(negedge clk);
    last = glog[$];
    glog.delete();
    for (int i = 0; i < NM; i++) begin
      fork
        automatic int k = i;
        begin logic [DW-1:0] x; txn(k, OP_RD, AW'(k), '0, x); end
      join_none
    end
    wait fork;
    for (int k = 0; k < NM; k++)
      chk(glog.size() > k && glog[k] == (last + 1 + k) % NM, "R7", "round-robin order",
          glog.size() > k ? glog[k] : -1, (last + 1 + k) % NM);

    ready_pct = 25;
    fork
      begin logic [DW-1:0] x; txn(2, OP_SW, 8'd41, 16'h7777, x); end
      begin logic [DW-1:0] x; @(negedge clk); txn(0, OP_RD, 8'd90, '0, x); end
      begin logic [DW-1:0] x; @(negedge clk); txn(1, OP_WR, 8'd91, 16'h0101, x); end
      begin logic [DW-1:0] x; @(negedge clk); txn(3, OP_RD, 8'd92, '0, x); end
    join
    chk(model[41] == 16'h7777, "R4", "slow swap stored", model[41], 16'h7777);

    ready_pct = 60;
    for (int i = 0; i < NM; i++) begin
      fork
        automatic int k = i;
        spinner(k, 6);
      join_none
    end
    wait fork;
    chk(holders == 0 && model[0] == '0, "R10", "lock free at end", holders, 0);

    ready_pct = 50;
    for (int i = 0; i < NM; i++) begin
      fork
        automatic int k = i;
        mixer(k, 25);
      join_none
    end
    wait fork;

    repeat (4) @(negedge clk);
    for (int i = 0; i < NM; i++)
      chk(fin_cnt[i] == txn_cnt[i], "R9", "one completion per request", fin_cnt[i], txn_cnt[i]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule